// File: doc/BRIEF.md
# Register Rename Stage with Zero-Idiom and Move Elimination

This block is the rename step of a small out-of-order core. Each cycle it can accept one decoded micro-operation (uop) through a valid/ready handshake. It looks up the physical names of the uop's sources in an alias table, records the destination's old physical name in an internal reorder buffer (ROB), and gives the destination a new physical name. Ordinary uops get a register from a pool of physical registers and are dispatched to the reservation station together with their ROB slot.

Two kinds of uop are finished at rename and are never dispatched. The first is an XOR whose two sources name the same architectural register. Its destination is remapped to physical register 0, which is hardwired to zero. The second is a register-to-register move. Its destination is pointed at the physical register that currently holds the source. Both kinds enter the ROB already marked complete, and neither takes a register from the pool.

Each physical register has a reference count, so a register shared through move elimination is freed only when its last mapping is released. A mapping is released when the ROB entry that overwrote it commits. The block also keeps two event counters: one for uops issued into the ROB and one for operations sent to execution.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i+1. The free count equals NUM_PHYS-1-NUM_ARCH, both counters are zero, and the ROB is empty.
- R2: An accepted uop with in_op=1 (XOR) and in_src1==in_src2 is a zero idiom. It raises no rs_valid, writes the ROB with rob_wr_done=1, remaps in_dst to physical register 0, and takes no register from the pool.
- R3: An accepted uop with in_op=2 (move) raises no rs_valid and writes the ROB with rob_wr_done=1. It maps in_dst to the current physical register of in_src1 and increments that register's reference count instead of allocating.
- R4: Every other accepted uop (in_op=0 ALU, in_op=3 load, or XOR with different sources) takes the lowest-numbered free physical register above 0. It raises rs_valid with the renamed sources, that destination and its ROB index, and writes the ROB with rob_wr_done=0.
- R5: in_ready is low when the ROB is full. It is also low when the pool is empty and the uop is not eliminated. An eliminated uop is accepted while the ROB has space, even with an empty pool.
- R6: A physical register returns to the pool only when its reference count reaches zero. Committing an entry decrements the count of the old mapping that entry holds. Physical register 0 is never counted and never enters the pool.
- R7: issued_cnt increases by exactly one for every uop accepted into the ROB, eliminated ones included.
- R8: executed_cnt increases by one for each dispatched uop, by two if in_fused is set, and not at all for eliminated uops.
- R9: wb_valid with wb_idx marks that ROB entry complete. With commit_en high, the oldest entry commits once it is complete, presenting its old mapping on commit_prev_p. Commit is strictly in allocation order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded uop present |
| in_ready | output | 1 | Uop accepted this cycle when in_valid is high |
| in_op | input | 2 | 0 ALU, 1 XOR, 2 move, 3 load |
| in_src1 | input | AW | First architectural source |
| in_src2 | input | AW | Second architectural source |
| in_dst | input | AW | Architectural destination |
| in_fused | input | 1 | Uop carries a fused load and ALU operation |
| rs_valid | output | 1 | Dispatch to reservation station |
| rs_src1_p | output | PW | Renamed first source |
| rs_src2_p | output | PW | Renamed second source |
| rs_dst_p | output | PW | Allocated destination |
| rs_rob_idx | output | IW | ROB slot of the dispatched uop |
| rob_wr_valid | output | 1 | ROB entry written |
| rob_wr_idx | output | IW | Index of the written ROB entry |
| rob_wr_done | output | 1 | Entry written already complete |
| wb_valid | input | 1 | Execution completion |
| wb_idx | input | IW | ROB slot that completed |
| commit_en | input | 1 | Permit the oldest complete entry to commit |
| commit_valid | output | 1 | An entry commits this cycle |
| commit_prev_p | output | PW | Old mapping released by the commit |
| free_cnt | output | FCW | Physical registers currently free |
| issued_cnt | output | CNT_W | Uops written into the ROB |
| executed_cnt | output | CNT_W | Operations sent to execution |
| rat_flat | output | NUM_ARCH*PW | Alias table, architectural register i at bits [i*PW +: PW] |

## Verification
Rename and commit can both act on the same reference counter in one cycle. This happens when a move increments a register while a commit releases an older mapping of that same register, or when a new allocation and a commit both touch the pool. The random streams include frequent moves, zero idioms and destinations drawn from a small register set, with commit enabled on most cycles, so these collisions occur often. The bench model applies the commit release and the rename increment to its own counts in the same step. It then compares the free count and the whole alias table on the next cycle. An early phase with commit held off drains the pool, which exposes the stall rule while eliminated uops still enter the ROB.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_XOR  = 2'd1,
        OP_MOV  = 2'd2,
        OP_LOAD = 2'd3
    } rn_op_e;

    typedef enum logic [1:0] {
        CLS_EXEC = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_MOVE = 2'd2
    } rn_cls_e;
endpackage

// File: rtl/rn_classify.sv
module rn_classify
    import rn_pkg::*;
#(
    parameter int AW = 3
) (
    input  rn_op_e        op,
    input  logic [AW-1:0] src1,
    input  logic [AW-1:0] src2,
    output rn_cls_e       cls
);
    always_comb begin
        cls = CLS_EXEC;
        if (op == OP_XOR && src1 == src2) begin
            cls = CLS_ZERO;
        end else if (op == OP_MOV) begin
            cls = CLS_MOVE;
        end
    end
endmodule

// File: rtl/rn_phys_pool.sv
module rn_phys_pool #(
    parameter int NUM_PHYS  = 16,
    parameter int NUM_ARCH  = 8,
    parameter int ROB_DEPTH = 8,
    localparam int PW  = $clog2(NUM_PHYS),
    localparam int FCW = $clog2(NUM_PHYS + 1),
    localparam int RCW = $clog2(NUM_ARCH + ROB_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc_en,
    input  logic [PW-1:0]  inc_p,
    input  logic           dec_en,
    input  logic [PW-1:0]  dec_p,
    output logic           alloc_avail,
    output logic [PW-1:0]  alloc_p,
    output logic [FCW-1:0] free_cnt
);
    typedef struct packed {
        logic [NUM_PHYS-1:0][RCW-1:0] rc;
    } pool_st_t;

    pool_st_t st_d, st_q;

    function automatic pool_st_t pool_reset();
        pool_st_t r;
        for (int p = 0; p < NUM_PHYS; p++) begin
            r.rc[p] = (p >= 1 && p <= NUM_ARCH) ? RCW'(1) : '0;
        end
        return r;
    endfunction

    // next-state: rename increment and commit release may hit one register
    always_comb begin
        st_d = st_q;
        if (inc_en && inc_p != '0) begin
            st_d.rc[inc_p] = st_d.rc[inc_p] + RCW'(1);
        end
        if (dec_en && dec_p != '0) begin
            st_d.rc[dec_p] = st_d.rc[dec_p] - RCW'(1);
        end
    end

    // lowest-numbered free register above the zero register
    always_comb begin
        alloc_avail = 1'b0;
        alloc_p     = '0;
        free_cnt    = '0;
        for (int p = NUM_PHYS - 1; p >= 1; p--) begin
            if (st_q.rc[p] == '0) begin
                alloc_avail = 1'b1;
                alloc_p     = PW'(p);
                free_cnt    = free_cnt + FCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= pool_reset();
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
    parameter int DEPTH = 8,
    parameter int PW    = 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [PW-1:0] alloc_prev,
    input  logic          alloc_done,
    output logic [IW-1:0] alloc_idx,
    output logic          full,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic          commit_en,
    output logic          commit_fire,
    output logic [PW-1:0] commit_prev
);
    typedef struct packed {
        logic [IW-1:0]             head;
        logic [IW-1:0]             tail;
        logic [IW:0]               cnt;
        logic [DEPTH-1:0]          done;
        logic [DEPTH-1:0][PW-1:0]  prev;
    } rob_st_t;

    rob_st_t st_d, st_q;

    assign alloc_idx   = st_q.tail;
    assign full        = (st_q.cnt == (IW+1)'(DEPTH));
    assign commit_fire = commit_en && (st_q.cnt != '0) && st_q.done[st_q.head];
    assign commit_prev = st_q.prev[st_q.head];

    always_comb begin
        st_d = st_q;
        if (commit_fire) begin
            st_d.head = st_q.head + IW'(1);
        end
        if (wb_en) begin
            st_d.done[wb_idx] = 1'b1;
        end
        if (alloc_en) begin
            st_d.prev[st_q.tail] = alloc_prev;
            st_d.done[st_q.tail] = alloc_done;
            st_d.tail            = st_q.tail + IW'(1);
        end
        st_d.cnt = st_q.cnt + (IW+1)'(alloc_en) - (IW+1)'(commit_fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rename_stage.sv
module rename_stage
    import rn_pkg::*;
#(
    parameter int NUM_ARCH  = 8,
    parameter int NUM_PHYS  = 16,
    parameter int ROB_DEPTH = 8,
    parameter int CNT_W     = 16,
    localparam int AW  = $clog2(NUM_ARCH),
    localparam int PW  = $clog2(NUM_PHYS),
    localparam int IW  = $clog2(ROB_DEPTH),
    localparam int FCW = $clog2(NUM_PHYS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [1:0]             in_op,
    input  logic [AW-1:0]          in_src1,
    input  logic [AW-1:0]          in_src2,
    input  logic [AW-1:0]          in_dst,
    input  logic                   in_fused,
    output logic                   rs_valid,
    output logic [PW-1:0]          rs_src1_p,
    output logic [PW-1:0]          rs_src2_p,
    output logic [PW-1:0]          rs_dst_p,
    output logic [IW-1:0]          rs_rob_idx,
    output logic                   rob_wr_valid,
    output logic [IW-1:0]          rob_wr_idx,
    output logic                   rob_wr_done,
    input  logic                   wb_valid,
    input  logic [IW-1:0]          wb_idx,
    input  logic                   commit_en,
    output logic                   commit_valid,
    output logic [PW-1:0]          commit_prev_p,
    output logic [FCW-1:0]         free_cnt,
    output logic [CNT_W-1:0]       issued_cnt,
    output logic [CNT_W-1:0]       executed_cnt,
    output logic [NUM_ARCH*PW-1:0] rat_flat
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][PW-1:0] rat;
        logic [CNT_W-1:0]            issued;
        logic [CNT_W-1:0]            executed;
    } ren_st_t;

    ren_st_t st_d, st_q;

    rn_cls_e        cls;
    logic           accept;
    logic           elim;
    logic           alloc_avail;
    logic [PW-1:0]  alloc_p;
    logic [PW-1:0]  src1_p;
    logic [PW-1:0]  src2_p;
    logic [PW-1:0]  prev_p;
    logic [PW-1:0]  new_p;
    logic           pool_inc;
    logic [PW-1:0]  pool_inc_p;
    logic           rob_full;
    logic [IW-1:0]  rob_idx;

    rn_classify #(.AW(AW)) u_cls (
        .op   (rn_op_e'(in_op)),
        .src1 (in_src1),
        .src2 (in_src2),
        .cls  (cls)
    );

    rn_phys_pool #(
        .NUM_PHYS  (NUM_PHYS),
        .NUM_ARCH  (NUM_ARCH),
        .ROB_DEPTH (ROB_DEPTH)
    ) u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_en      (pool_inc),
        .inc_p       (pool_inc_p),
        .dec_en      (commit_valid),
        .dec_p       (commit_prev_p),
        .alloc_avail (alloc_avail),
        .alloc_p     (alloc_p),
        .free_cnt    (free_cnt)
    );

    rn_rob #(.DEPTH(ROB_DEPTH), .PW(PW)) u_rob (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (accept),
        .alloc_prev  (prev_p),
        .alloc_done  (elim),
        .alloc_idx   (rob_idx),
        .full        (rob_full),
        .wb_en       (wb_valid),
        .wb_idx      (wb_idx),
        .commit_en   (commit_en),
        .commit_fire (commit_valid),
        .commit_prev (commit_prev_p)
    );

    // lookup and handshake
    assign elim     = (cls != CLS_EXEC);
    assign in_ready = !rob_full && (elim || alloc_avail);
    assign accept   = in_valid && in_ready;
    assign src1_p   = st_q.rat[in_src1];
    assign src2_p   = st_q.rat[in_src2];
    assign prev_p   = st_q.rat[in_dst];

    always_comb begin
        unique case (cls)
            CLS_ZERO: new_p = '0;
            CLS_MOVE: new_p = src1_p;
            default:  new_p = alloc_p;
        endcase
    end

    // a zero idiom takes no reference; a move shares the source register
    assign pool_inc   = accept && (cls != CLS_ZERO);
    assign pool_inc_p = new_p;

    assign rs_valid     = accept && !elim;
    assign rs_src1_p    = src1_p;
    assign rs_src2_p    = src2_p;
    assign rs_dst_p     = alloc_p;
    assign rs_rob_idx   = rob_idx;
    assign rob_wr_valid = accept;
    assign rob_wr_idx   = rob_idx;
    assign rob_wr_done  = elim;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.rat[in_dst] = new_p;
            st_d.issued      = st_q.issued + CNT_W'(1);
        end
        if (rs_valid) begin
            st_d.executed = st_q.executed + (in_fused ? CNT_W'(2) : CNT_W'(1));
        end
    end

    function automatic ren_st_t ren_reset();
        ren_st_t r;
        r = '0;
        for (int a = 0; a < NUM_ARCH; a++) begin
            r.rat[a] = PW'(a + 1);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ren_reset();
        end else begin
            st_q <= st_d;
        end
    end

    assign issued_cnt   = st_q.issued;
    assign executed_cnt = st_q.executed;

    for (genvar a = 0; a < NUM_ARCH; a++) begin : g_flat
        assign rat_flat[a*PW +: PW] = st_q.rat[a];
    end
endmodule

// File: rtl/rename_stage_chk.sv
module rename_stage_chk #(
    parameter int NUM_ARCH  = 8,
    parameter int NUM_PHYS  = 16,
    parameter int CNT_W     = 16,
    parameter int AW        = 3,
    parameter int PW        = 4,
    parameter int FCW       = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [1:0]             in_op,
    input logic [AW-1:0]          in_src1,
    input logic [AW-1:0]          in_src2,
    input logic [AW-1:0]          in_dst,
    input logic                   rs_valid,
    input logic                   rob_wr_done,
    input logic                   commit_valid,
    input logic [FCW-1:0]         free_cnt,
    input logic [CNT_W-1:0]       issued_cnt,
    input logic [CNT_W-1:0]       executed_cnt,
    input logic [NUM_ARCH*PW-1:0] rat_flat
);
    logic acc, is_zero, is_move;
    logic          zero_seen_q;
    logic [AW-1:0] zero_dst_q;

    assign acc     = in_valid && in_ready;
    assign is_zero = (in_op == 2'd1) && (in_src1 == in_src2);
    assign is_move = (in_op == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_seen_q <= 1'b0;
            zero_dst_q  <= '0;
        end else begin
            zero_seen_q <= acc && is_zero;
            zero_dst_q  <= in_dst;
        end
    end

    // R2
    zero_no_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_zero) |-> (!rs_valid && rob_wr_done));

    // R2
    zero_maps_reg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_seen_q |-> (rat_flat[zero_dst_q*PW +: PW] == '0));

    // R2
    zero_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_zero && !commit_valid) |=> (free_cnt == $past(free_cnt)));

    // R3
    move_no_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_move) |-> (!rs_valid && rob_wr_done));

    // R5
    stall_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((free_cnt == '0) && !is_zero && !is_move) |-> !in_ready);

    // R6
    zero_never_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= FCW'(NUM_PHYS - 1));

    // R7
    issued_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (issued_cnt == $past(issued_cnt) + CNT_W'($past(acc))));

    // R8
    elim_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (is_zero || is_move)) |=> $stable(executed_cnt));
endmodule

bind rename_stage rename_stage_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS),
    .CNT_W    (CNT_W),
    .AW       (AW),
    .PW       (PW),
    .FCW      (FCW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_op        (in_op),
    .in_src1      (in_src1),
    .in_src2      (in_src2),
    .in_dst       (in_dst),
    .rs_valid     (rs_valid),
    .rob_wr_done  (rob_wr_done),
    .commit_valid (commit_valid),
    .free_cnt     (free_cnt),
    .issued_cnt   (issued_cnt),
    .executed_cnt (executed_cnt),
    .rat_flat     (rat_flat)
);

// File: tb/rename_stage_test.sv
module rename_stage_test;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 8, NP = 16, RD = 8, CW = 16;
    localparam int AW = 3, PW = 4, IW = 3, FCW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_fused = 1'b0, wb_valid = 1'b0, commit_en = 1'b0;
    logic [1:0] in_op = '0;
    logic [AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic [IW-1:0] wb_idx = '0;
    logic in_ready, rs_valid, rob_wr_valid, rob_wr_done, commit_valid;
    logic [PW-1:0] rs_src1_p, rs_src2_p, rs_dst_p, commit_prev_p;
    logic [IW-1:0] rs_rob_idx, rob_wr_idx;
    logic [FCW-1:0] free_cnt;
    logic [CW-1:0] issued_cnt, executed_cnt;
    logic [NA*PW-1:0] rat_flat;

    rename_stage uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int m_rat[NA], m_rc[NP], m_prev[RD], m_done[RD];
    int m_head = 0, m_tail = 0, m_cnt = 0, m_issued = 0, m_exec = 0;
    int pending[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_free();
        int n = 0;
        for (int p = 1; p < NP; p++) if (m_rc[p] == 0) n++;
        return n;
    endfunction

    function automatic int m_lowest();
        for (int p = 1; p < NP; p++) if (m_rc[p] == 0) return p;
        return 0;
    endfunction

    task automatic check_state(input string tag);
        for (int a = 0; a < NA; a++)
            chk({tag, " R2 R3 alias"}, int'(rat_flat[a*PW +: PW]), m_rat[a]);
        chk({tag, " R6 free_cnt"}, int'(free_cnt), m_free());
        chk({tag, " R7 issued"}, int'(issued_cnt), m_issued);
        chk({tag, " R8 executed"}, int'(executed_cnt), m_exec);
    endtask

    // one cycle: drive, check combinational outputs, advance the model
    task automatic step(input bit allow_commit, input bit allow_wb, input bit force_valid);
        int cls, alloc, np, exp_ready, exp_commit, r;
        @(negedge clk);
        check_state("state");
        r = $urandom_range(0, 9);
        in_valid = force_valid || ($urandom_range(0, 9) < 8);
        in_op    = 2'(r < 3 ? 1 : (r < 5 ? 2 : $urandom_range(0, 3)));
        in_dst   = AW'($urandom_range(0, NA - 1));
        in_src1  = AW'($urandom_range(0, NA - 1));
        in_src2  = (r < 2) ? in_src1 : AW'($urandom_range(0, NA - 1));
        in_fused = $urandom_range(0, 1) == 1;
        commit_en = allow_commit && ($urandom_range(0, 9) < 7);
        wb_valid = 1'b0;
        if (allow_wb && pending.size() > 0 && $urandom_range(0, 9) < 6) begin
            int k = $urandom_range(0, pending.size() - 1);
            wb_valid = 1'b1;
            wb_idx = IW'(pending[k]);
            pending.delete(k);
        end
        #1;
        cls = (in_op == 2'd1 && in_src1 == in_src2) ? 1 : (in_op == 2'd2 ? 2 : 0);
        alloc = m_lowest();
        exp_ready = (m_cnt < RD) && (cls != 0 || alloc != 0);
        exp_commit = commit_en && m_cnt > 0 && m_done[m_head] == 1;
        chk("R5 in_ready", int'(in_ready), exp_ready);
        chk("R9 commit_valid", int'(commit_valid), exp_commit);
        if (exp_commit) chk("R9 commit_prev", int'(commit_prev_p), m_prev[m_head]);
        chk("R4 rs_valid", int'(rs_valid), int'(in_valid && exp_ready && cls == 0));
        if (in_valid && exp_ready) begin
            chk("R2 R3 rob_wr_done", int'(rob_wr_done), int'(cls != 0));
            chk("R9 rob_wr_idx", int'(rob_wr_idx), m_tail);
            if (cls == 0) begin
                chk("R4 rs_dst", int'(rs_dst_p), alloc);
                chk("R4 rs_src1", int'(rs_src1_p), m_rat[in_src1]);
                chk("R4 rs_src2", int'(rs_src2_p), m_rat[in_src2]);
            end
        end
        // model update, same order of effects as required
        if (exp_commit) begin
            if (m_prev[m_head] != 0) m_rc[m_prev[m_head]]--;
            m_head = (m_head + 1) % RD;
            m_cnt--;
        end
        if (wb_valid) m_done[wb_idx] = 1;
        if (in_valid && exp_ready) begin
            np = (cls == 1) ? 0 : (cls == 2 ? m_rat[in_src1] : alloc);
            if (np != 0) m_rc[np]++;
            m_prev[m_tail] = m_rat[in_dst];
            m_done[m_tail] = (cls != 0);
            if (cls == 0) pending.push_back(m_tail);
            m_rat[in_dst] = np;
            m_tail = (m_tail + 1) % RD;
            m_cnt++;
            m_issued++;
            if (cls == 0) m_exec += in_fused ? 2 : 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) m_rat[a] = a + 1;
        for (int p = 0; p < NP; p++) m_rc[p] = (p >= 1 && p <= NA) ? 1 : 0;
        for (int e = 0; e < RD; e++) begin m_prev[e] = 0; m_done[e] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < NA; a++)
            chk("R1 reset alias", int'(rat_flat[a*PW +: PW]), a + 1);
        chk("R1 reset free_cnt", int'(free_cnt), NP - 1 - NA);
        chk("R1 reset issued", int'(issued_cnt), 0);
        chk("R1 reset executed", int'(executed_cnt), 0);
        chk("R1 reset in_ready", int'(in_ready), 1);
        chk("R1 reset commit_valid", int'(commit_valid), 0);
        // pool and ROB drain with nothing retiring: exercises R5
        for (int c = 0; c < 30; c++) step(1'b0, 1'b0, 1'b1);
        // mixed traffic with completions and commits
        for (int c = 0; c < 3000; c++) step(1'b1, 1'b1, 1'b0);
        // second starvation burst then drain
        for (int c = 0; c < 20; c++) step(1'b0, 1'b0, 1'b1);
        for (int c = 0; c < 2000; c++) step(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check_state("final");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule